// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns a signed product of `2N` bits. It handles one recoded multiplier bit per clock cycle. Each cycle it looks at the current low bit of the multiplier and at the bit seen just before it. Depending on that pair, it adds the multiplicand into the upper half of the product, subtracts it, or leaves the upper half alone. It then shifts the whole product right by one place, copying the sign bit into the top.

The multiplier register is not used up as the product fills. Instead it rotates right once per step, so after `N` steps it holds its original value again. A separate flip-flop remembers the bit that most recently left the bottom of the multiplier.

The caller drives the operands and raises `start` for one cycle. `start` works like a valid signal, and `busy` works like an inverted ready. The block only takes operands in a cycle where `busy` is low. A `start` that arrives while `busy` is high is dropped and is not queued, so the caller must hold the request until `busy` is low. There is no back-pressure on the result side. The block raises `done` for a single cycle, and `product` holds the result from that cycle until the next request is accepted.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: When `start` is 1 and `busy` is 0 at a rising edge, the operands are captured at that edge and `busy` is 1 in the following cycle.
- R3: When `done` is 1, `product` equals the signed product of the captured operands, as a `2N`-bit two's-complement value.
- R4: The result is correct at the ends of the range. This includes the most negative multiplicand used with a multiplier whose Booth pair asks for a subtraction, for example (-8)×(-8)=64 and (-8)×7=-56 when N=4.
- R5: After acceptance, `busy` stays 1 for exactly `N` cycles. `done` is 1 in the cycle right after the last busy cycle, which is `N` edges after the accepting edge.
- R6: `done` lasts exactly one cycle, and `done` and `busy` are never 1 together.
- R7: A `start` raised while `busy` is 1 has no effect. The running operation returns the product of the operands it accepted, and no extra result follows.
- R8: `product` stays unchanged from the `done` cycle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; accepted only when `busy` is 0 |
| multiplicand | input | N | Signed multiplicand, captured on acceptance |
| multiplier | input | N | Signed multiplier, captured on acceptance |
| busy | output | 1 | Operation in progress; new requests are ignored |
| done | output | 1 | One-cycle pulse; `product` is valid |
| product | output | 2N | Signed product, held after `done` |

## Verification
The bench runs all 256 pairs of 4-bit operands, with special attention to the most negative multiplicand. If the add and subtract were only N bits wide, subtracting -8 would wrap, and (-8)×(-8) would come out negative or far too small. The bench also checks the pairs with equal signs and the pairs with zero operands. A design whose shift was logical instead of arithmetic would fail these, because it would fill the top with zeros and lose the sign of negative partial products. Each result is also timed to exactly `N` steps: an off-by-one counter would either drop the last recoded bit or process a rotated bit twice. A second `start` is sent in the middle of a run. If the design took it, the operands would be replaced, the first result would be wrong, and an extra `done` would appear.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Action chosen from the pair (current multiplier LSB, previous bit)
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b01:   op = OP_ADD;
      2'b10:   op = OP_SUB;
      default: op = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  booth_op_e    op,
  output logic [W-1:0] result
);
  always_comb begin
    unique case (op)
      OP_ADD:  result = acc + operand;
      OP_SUB:  result = acc + (~operand) + W'(1);
      default: result = acc;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          last;

  assign accept = start && !busy_q;
  assign step   = busy_q;
  assign last   = busy_q && (cnt_q == CW'(N - 1));
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int UW = N + 1;  // accumulator width keeps the sign of -(-2^(N-1))

  logic [N-1:0]  mcand_q;
  logic [N-1:0]  mplier_q;
  logic          xprev_q;
  logic [UW-1:0] upper_q;
  logic [N-1:0]  lower_q;
  logic [UW-1:0] sum;
  booth_op_e     op;
  logic          accept;
  logic          step;

  booth_ctrl #(.N(N)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .step   (step),
    .busy   (busy),
    .done   (done)
  );

  booth_recode recode_i (
    .cur_bit  (mplier_q[0]),
    .prev_bit (xprev_q),
    .op       (op)
  );

  booth_addsub #(.W(UW)) addsub_i (
    .acc     (upper_q),
    .operand ({mcand_q[N-1], mcand_q}),
    .op      (op),
    .result  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      xprev_q  <= 1'b0;
      upper_q  <= '0;
      lower_q  <= '0;
    end else if (accept) begin
      mcand_q  <= multiplicand;
      mplier_q <= multiplier;
      xprev_q  <= 1'b0;
      upper_q  <= '0;
      lower_q  <= '0;
    end else if (step) begin
      // arithmetic right shift of {upper, lower} after the add/sub
      upper_q  <= {sum[UW-1], sum[UW-1:1]};
      lower_q  <= {sum[0], lower_q[N-1:1]};
      // rotate the multiplier; remember the bit leaving the bottom
      xprev_q  <= mplier_q[0];
      mplier_q <= {mplier_q[0], mplier_q[N-1:1]};
    end
  end

  assign product = {upper_q[N-1:0], lower_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N-1:0]   multiplicand,
  input logic [N-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic [N-1:0]   mplier_q,
  input logic [N-1:0]   mcand_q
);
  logic [N-1:0]          a_cap, b_cap;
  logic [31:0]           busy_cnt;
  logic signed [2*N-1:0] expect_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap    <= '0;
      b_cap    <= '0;
      busy_cnt <= '0;
    end else if (start && !busy) begin
      a_cap    <= multiplicand;
      b_cap    <= multiplier;
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 32'd1;
    end
  end

  always_comb
    expect_p = $signed({{N{a_cap[N-1]}}, a_cap}) * $signed({{N{b_cap[N-1]}}, b_cap});

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_product_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed(product) == expect_p));

  // R3: after N rotations the multiplier register is back to its captured value
  assert_rotation_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (mplier_q == b_cap));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 32'(N)));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mcand_q));

  assert_hold_product_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && $past(!busy)) |=> $stable(product));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product),
  .mplier_q     (mplier_q),
  .mcand_q      (mcand_q)
);

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;
  localparam int N = 4;
  localparam int NV = 12;
  // each entry: {multiplicand, multiplier, expected product}
  localparam logic [15:0] VEC [NV] = '{
    {4'h2, 4'hC, 8'hF8},  //  2 * -4 = -8
    {4'h8, 4'h8, 8'h40},  // -8 * -8 = 64
    {4'h8, 4'h7, 8'hC8},  // -8 *  7 = -56
    {4'h7, 4'h7, 8'h31},  //  7 *  7 = 49
    {4'hF, 4'hF, 8'h01},  // -1 * -1 = 1
    {4'h0, 4'h8, 8'h00},  //  0 * -8 = 0
    {4'h8, 4'h1, 8'hF8},  // -8 *  1 = -8
    {4'h3, 4'hB, 8'hF1},  //  3 * -5 = -15
    {4'h9, 4'h6, 8'hD6},  // -7 *  6 = -42
    {4'h5, 4'h0, 8'h00},  //  5 *  0 = 0
    {4'hF, 4'h7, 8'hF9},  // -1 *  7 = -7
    {4'h6, 4'hE, 8'hF4}   //  6 * -2 = -12
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  booth_seq_mult #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Issues one request; returns product and the number of negedges until done
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        output logic [2*N-1:0] p, output int lat);
    @(negedge clk);
    multiplicand = a; multiplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", int'(busy), 1);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    p = product;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2*N-1:0] p;
    logic [2*N-1:0] p_hold;
    int lat;
    int seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 product in reset", int'(product), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 product after reset", int'(product), 0);

    // Table of vectors, R3/R4 values and R5 latency (done N+1 negedges after driving start)
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][15:12], VEC[i][11:8], p, lat);
      check("R4 table product", int'($signed(p)), int'($signed(VEC[i][7:0])));
      check("R5 latency", lat, N + 1);
    end

    // Exhaustive 4-bit sweep against a behavioural multiply (R3)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(N'(a), N'(b), p, lat);
        check("R3 product", int'($signed(p)),
              int'($signed(N'(a))) * int'($signed(N'(b))));
      end
    end

    // R6: done is a single-cycle pulse and never overlaps busy
    run_op(4'h3, 4'h5, p, lat);
    check("R6 done with busy", int'(busy), 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);

    // R8: product held while idle
    p_hold = product;
    repeat (3) @(negedge clk);
    check("R8 product held", int'(product), int'(p_hold));

    // R7: start while busy is ignored
    @(negedge clk);
    multiplicand = 4'h7; multiplier = 4'h3; start = 1'b1;  // 7*3 = 21
    @(negedge clk);
    multiplicand = 4'h8; multiplier = 4'h8;                // held high while busy
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    while (!done && seen < 40) begin
      @(negedge clk);
      seen++;
    end
    check("R7 first result kept", int'($signed(product)), 21);
    seen = 0;
    for (int k = 0; k < N + 3; k++) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    check("R7 no second result", seen, 0);
    check("R7 product unchanged", int'($signed(product)), 21);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule